// File: doc/BRIEF.md
# Interrupt-Capable Three-Port GPIO Unit

This block provides three 8-bit general-purpose I/O ports, called A, B and F, on a small synchronous byte-wide register bus. Each port has output data and direction registers. Each pin can raise an interrupt from its input, either while the input sits at a chosen level or when a chosen edge arrives. An edge leaves a pending flag that software clears by writing a one to that pin's end-of-interrupt bit.

Pad inputs pass through a two-flop synchronizer. Each pin can also have a glitch filter, which only accepts a new value after it has been seen on several consecutive sample ticks from a clock divider. The pending pins of ports A and B are ORed onto one shared interrupt request. Port F has one interrupt request per pin.

Software reads a per-port status register to find which enabled pins are pending. All registers clear on reset. The bus read path is combinational: `rd_data` shows the register at `addr` in the same cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every mapped register reads 0, all output enables are 0 (every pin is an input), and `irq_ab` and `irq_f` are low.
- R2: For each pin, a direction bit of 1 drives `pad_*_out` from the data register and raises `pad_*_oe`. A read of the data register returns the register bit for output pins and the synchronized pad value for input pins. Data/direction offsets are 0x00/0x10 (A), 0x04/0x14 (B) and 0x30/0x34 (F). An unmapped address reads 0, and a write to it changes no register.
- R3: In level mode (mode bit 0), an enabled pin is pending while its filtered input equals its polarity bit (1 = high, 0 = low). An end-of-interrupt write does not clear it.
- R4: In edge mode (mode bit 1), an enabled pin latches pending on a rising edge when its polarity bit is 1 and on a falling edge when it is 0. The other edge is ignored. The flag stays set after the input returns. Writing 1 to the pin's end-of-interrupt bit clears it, and end-of-interrupt bits written as 0 do nothing.
- R5: If an edge is detected in the same cycle as an end-of-interrupt write to that pin, the pin stays pending.
- R6: A pin whose enable bit is 0 shows no status and raises no interrupt. Leaving edge-enabled operation discards a held edge. Enabling edge mode while the input already sits at its active level raises nothing.
- R7: `irq_ab` is high exactly when any status bit of port A or B is set. `irq_f[i]` equals status bit i of port F. Port F never affects `irq_ab`.
- R8: When a pin's debounce bit is 1, its filtered input only takes a new value after the synchronized input has differed from it on 4 consecutive sample ticks. A tick occurs once every `DB_DIV` clocks, counted from reset release. Shorter pulses are dropped.
- R9: With debounce off, an input change seen at a clock edge sets the synchronizer's first stage. In edge mode the status bit changes at the fourth clock edge; in level mode it changes at the third.
- R10: Interrupt register offsets for A/B/F: mode 0x90/0xAC/0x4C, polarity 0x94/0xB0/0x50, end-of-interrupt 0x98/0xB4/0x54 (reads 0), enable 0x9C/0xB8/0x58, debounce 0xA8/0xC4/0x64, status 0xA0/0xBC/0x5C (read only). The written registers read back their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, same cycle |
| pad_a_in | input | 8 | Port A pad inputs |
| pad_a_out | output | 8 | Port A output values |
| pad_a_oe | output | 8 | Port A output enables |
| pad_b_in | input | 8 | Port B pad inputs |
| pad_b_out | output | 8 | Port B output values |
| pad_b_oe | output | 8 | Port B output enables |
| pad_f_in | input | 8 | Port F pad inputs |
| pad_f_out | output | 8 | Port F output values |
| pad_f_oe | output | 8 | Port F output enables |
| irq_ab | output | 1 | Shared interrupt request of ports A and B |
| irq_f | output | 8 | Per-pin interrupt requests of port F |

## Verification
The bench aims an end-of-interrupt write at the exact cycle in which a new edge lands. A design that lets the clear win would lose that interrupt and show the status bit low. It enables edge mode while the input already sits at its active level; a design with a stale previous-sample register would fire a spurious interrupt there. It also sends pulses shorter than the filter window and checks the exact clock at which a status bit first appears. These catch filters that count clocks instead of ticks and pipelines one stage too long or too short. End-of-interrupt writes with zero bits or aimed at level-mode pins must leave status unchanged; a design that cleared on any write would drop them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT = 3;
  localparam int AW    = 8;

  typedef enum logic [1:0] {PORT_A = 2'd0, PORT_B = 2'd1, PORT_F = 2'd2} port_id_e;

  // byte offsets of one port's registers
  typedef struct packed {
    logic [7:0] dat;
    logic [7:0] dir;
    logic [7:0] edg;
    logic [7:0] pol;
    logic [7:0] eoi;
    logic [7:0] en;
    logic [7:0] deb;
    logic [7:0] sts;
  } regmap_t;

  function automatic regmap_t port_map(port_id_e id);
    regmap_t m;
    case (id)
      PORT_A:  m = '{dat: 8'h00, dir: 8'h10, edg: 8'h90, pol: 8'h94,
                     eoi: 8'h98, en: 8'h9C, deb: 8'hA8, sts: 8'hA0};
      PORT_B:  m = '{dat: 8'h04, dir: 8'h14, edg: 8'hAC, pol: 8'hB0,
                     eoi: 8'hB4, en: 8'hB8, deb: 8'hC4, sts: 8'hBC};
      default: m = '{dat: 8'h30, dir: 8'h34, edg: 8'h4C, pol: 8'h50,
                     eoi: 8'h54, en: 8'h58, deb: 8'h64, sts: 8'h5C};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int DB_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flt_en,
  input  logic d,
  output logic q
);
  localparam int CW = (DB_CNT > 1) ? $clog2(DB_CNT) : 1;

  logic          q_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    q_d   = q;
    cnt_d = cnt_q;
    if (!flt_en) begin
      q_d   = d;
      cnt_d = '0;
    end else if (tick) begin
      if (d != q) begin
        if (cnt_q == CW'(DB_CNT - 1)) begin
          q_d   = d;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= 1'b0;
      cnt_q <= '0;
    end else begin
      q     <= q_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int       PW     = 8,
  parameter int       DB_CNT = 4,
  parameter port_id_e PID    = PORT_A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  input  logic [PW-1:0] pin_i,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe,
  output logic [PW-1:0] rd_o,
  output logic [PW-1:0] stat_o,
  output logic [PW-1:0] arm_o,
  output logic [PW-1:0] hit_o,
  output logic [PW-1:0] filt_o,
  output logic [PW-1:0] deb_o
);
  localparam regmap_t M = port_map(PID);

  logic [PW-1:0] dat_q, dir_q, edg_q, pol_q, en_q, deb_q, stk_q, prv_q;
  logic [PW-1:0] dat_d, dir_d, edg_d, pol_d, en_d, deb_d, stk_d, prv_d;
  logic [PW-1:0] syn, filt, eoi, arm, hit, lvl;

  gpio_sync2 #(.W(PW)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin_i), .q(syn));

  for (genvar i = 0; i < PW; i++) begin : g_db
    gpio_debounce #(.DB_CNT(DB_CNT)) u_db (
      .clk(clk), .rst_n(rst_n), .tick(tick), .flt_en(deb_q[i]),
      .d(syn[i]), .q(filt[i])
    );
  end

  // next state
  always_comb begin
    dat_d = dat_q;
    dir_d = dir_q;
    edg_d = edg_q;
    pol_d = pol_q;
    en_d  = en_q;
    deb_d = deb_q;
    eoi   = '0;
    if (wr_en) begin
      case (addr)
        M.dat:   dat_d = wr_data;
        M.dir:   dir_d = wr_data;
        M.edg:   edg_d = wr_data;
        M.pol:   pol_d = wr_data;
        M.en:    en_d  = wr_data;
        M.deb:   deb_d = wr_data;
        M.eoi:   eoi   = wr_data;
        default: ;
      endcase
    end
    arm   = en_q & edg_q;
    hit   = arm & ((pol_q & filt & ~prv_q) | (~pol_q & ~filt & prv_q));
    // a new edge beats a same-cycle clear; leaving edge mode drops the flag
    stk_d = ((stk_q & ~eoi) | hit) & en_d & edg_d;
    prv_d = filt;
  end

  assign lvl    = en_q & ~edg_q & ~(filt ^ pol_q);
  assign stat_o = (stk_q & arm) | lvl;
  assign pin_o  = dat_q;
  assign pin_oe = dir_q;
  assign arm_o  = arm;
  assign hit_o  = hit;
  assign filt_o = filt;
  assign deb_o  = deb_q;

  always_comb begin
    rd_o = '0;
    case (addr)
      M.dat:   rd_o = (dir_q & dat_q) | (~dir_q & syn);
      M.dir:   rd_o = dir_q;
      M.edg:   rd_o = edg_q;
      M.pol:   rd_o = pol_q;
      M.en:    rd_o = en_q;
      M.deb:   rd_o = deb_q;
      M.sts:   rd_o = stat_o;
      default: rd_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      dir_q <= '0;
      edg_q <= '0;
      pol_q <= '0;
      en_q  <= '0;
      deb_q <= '0;
      stk_q <= '0;
      prv_q <= '0;
    end else begin
      dat_q <= dat_d;
      dir_q <= dir_d;
      edg_q <= edg_d;
      pol_q <= pol_d;
      en_q  <= en_d;
      deb_q <= deb_d;
      stk_q <= stk_d;
      prv_q <= prv_d;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int PW     = 8,
  parameter int DB_DIV = 16,
  parameter int DB_CNT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] rd_data,
  input  logic [PW-1:0] pad_a_in,
  output logic [PW-1:0] pad_a_out,
  output logic [PW-1:0] pad_a_oe,
  input  logic [PW-1:0] pad_b_in,
  output logic [PW-1:0] pad_b_out,
  output logic [PW-1:0] pad_b_oe,
  input  logic [PW-1:0] pad_f_in,
  output logic [PW-1:0] pad_f_out,
  output logic [PW-1:0] pad_f_oe,
  output logic          irq_ab,
  output logic [PW-1:0] irq_f
);
  localparam int TW = (DB_DIV > 1) ? $clog2(DB_DIV) : 1;

  logic          rst_m, rst_i;
  logic [TW-1:0] div_q, div_d;
  logic          tick;

  logic [NPORT-1:0][PW-1:0] pin_in, pin_out, pin_oe, rd_v, stat_v, arm_v, hit_v, filt_v, deb_v;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_i <= rst_m;
    end
  end

  // debounce sample tick
  assign tick  = (div_q == TW'(DB_DIV - 1));
  assign div_d = tick ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) div_q <= '0;
    else        div_q <= div_d;
  end

  assign pin_in = {pad_f_in, pad_b_in, pad_a_in};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_irq_port #(.PW(PW), .DB_CNT(DB_CNT), .PID(port_id_e'(p))) u_port (
      .clk(clk), .rst_n(rst_i), .tick(tick),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .pin_i(pin_in[p]), .pin_o(pin_out[p]), .pin_oe(pin_oe[p]),
      .rd_o(rd_v[p]), .stat_o(stat_v[p]), .arm_o(arm_v[p]),
      .hit_o(hit_v[p]), .filt_o(filt_v[p]), .deb_o(deb_v[p])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPORT; p++) rd_data = rd_data | rd_v[p];
  end

  assign {pad_f_out, pad_b_out, pad_a_out} = pin_out;
  assign {pad_f_oe,  pad_b_oe,  pad_a_oe}  = pin_oe;
  assign irq_ab = |{stat_v[PORT_B], stat_v[PORT_A]};
  assign irq_f  = stat_v[PORT_F];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int PW = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [AW-1:0]            addr,
  input logic                     wr_en,
  input logic [PW-1:0]            wr_data,
  input logic                     tick,
  input logic                     irq_ab,
  input logic [NPORT-1:0][PW-1:0] stat,
  input logic [NPORT-1:0][PW-1:0] arm,
  input logic [NPORT-1:0][PW-1:0] hit,
  input logic [NPORT-1:0][PW-1:0] filt,
  input logic [NPORT-1:0][PW-1:0] deb
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    localparam logic [7:0] EOI_A = port_map(port_id_e'(p)).eoi;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (stat[p] & arm[p]) != '0) |=> ((stat[p] & $past(stat[p] & arm[p])) == $past(stat[p] & arm[p]))); // R4

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == EOI_A && hit[p] == '0) |=> ((stat[p] & $past(wr_data & arm[p])) == '0)); // R4

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[p] != '0 && (!wr_en || addr == EOI_A)) |=> ((stat[p] & $past(hit[p])) == $past(hit[p]))); // R5

    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && deb[p] != '0) |=> (((filt[p] ^ $past(filt[p])) & $past(deb[p])) == '0)); // R8
  end

  AST_SHARED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] != '0 || stat[1] != '0) |-> irq_ab); // R7
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_i), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .tick(tick), .irq_ab(irq_ab), .stat(stat_v), .arm(arm_v), .hit(hit_v),
  .filt(filt_v), .deb(deb_v)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] pad_a_in = 8'h00, pad_b_in = 8'h00, pad_f_in = 8'h00;
  logic [7:0] pad_a_out, pad_a_oe, pad_b_out, pad_b_oe, pad_f_out, pad_f_oe;
  logic       irq_ab;
  logic [7:0] irq_f;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.PW(8), .DB_DIV(DIV), .DB_CNT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data),
    .pad_a_in(pad_a_in), .pad_a_out(pad_a_out), .pad_a_oe(pad_a_oe),
    .pad_b_in(pad_b_in), .pad_b_out(pad_b_out), .pad_b_oe(pad_b_oe),
    .pad_f_in(pad_f_in), .pad_f_out(pad_f_out), .pad_f_oe(pad_f_oe),
    .irq_ab(irq_ab), .irq_f(irq_f)
  );

  // register offsets (R2, R10): data, dir, mode, polarity, eoi, enable, debounce, status
  localparam logic [7:0] OFF_A [8] = '{8'h00, 8'h10, 8'h90, 8'h94, 8'h98, 8'h9C, 8'hA8, 8'hA0};
  localparam logic [7:0] OFF_B [8] = '{8'h04, 8'h14, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hC4, 8'hBC};
  localparam logic [7:0] OFF_F [8] = '{8'h30, 8'h34, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h64, 8'h5C};

  function automatic logic [7:0] off(int p, int k);
    if (p == 0) return OFF_A[k];
    if (p == 1) return OFF_B[k];
    return OFF_F[k];
  endfunction

  function automatic logic [7:0] pad_of(int p);
    if (p == 0) return pad_a_in;
    if (p == 1) return pad_b_in;
    return pad_f_in;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_dat [3], m_dir [3], m_edg [3], m_pol [3], m_en [3], m_deb [3];
  logic [7:0] m_stk [3], m_prv [3], m_f [3];
  logic [7:0] m_pipe [3][$];    // synchronizer history, newest at back
  int         m_cnt [3][8];
  int         m_tc;
  bit         m_r1, m_r2;

  function automatic logic [7:0] m_s2(int p);
    return m_pipe[p][0];
  endfunction

  task automatic m_clear();
    for (int p = 0; p < 3; p++) begin
      m_dat[p] = 0; m_dir[p] = 0; m_edg[p] = 0; m_pol[p] = 0; m_en[p] = 0;
      m_deb[p] = 0; m_stk[p] = 0; m_prv[p] = 0; m_f[p] = 0;
      m_pipe[p] = '{8'h00, 8'h00};
      for (int i = 0; i < 8; i++) m_cnt[p][i] = 0;
    end
    m_tc = 0; m_r1 = 0; m_r2 = 0;
  endtask

  initial m_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear();
    end else begin
      if (m_r2) begin
        bit tk;
        tk = (m_tc == DIV - 1);
        m_tc = tk ? 0 : m_tc + 1;
        for (int p = 0; p < 3; p++) begin
          logic [7:0] nf, arm, hit, eoi, s2;
          s2 = m_s2(p);
          nf = m_f[p];
          for (int i = 0; i < 8; i++) begin
            if (!m_deb[p][i]) begin
              nf[i] = s2[i]; m_cnt[p][i] = 0;
            end else if (tk) begin
              if (s2[i] != m_f[p][i]) begin
                m_cnt[p][i]++;
                if (m_cnt[p][i] == 4) begin nf[i] = s2[i]; m_cnt[p][i] = 0; end
              end else m_cnt[p][i] = 0;
            end
          end
          arm = m_en[p] & m_edg[p];
          hit = arm & ((m_pol[p] & m_f[p] & ~m_prv[p]) | (~m_pol[p] & ~m_f[p] & m_prv[p]));
          eoi = 0;
          if (wr_en) begin
            if (addr == off(p, 0)) m_dat[p] = wr_data;
            if (addr == off(p, 1)) m_dir[p] = wr_data;
            if (addr == off(p, 2)) m_edg[p] = wr_data;
            if (addr == off(p, 3)) m_pol[p] = wr_data;
            if (addr == off(p, 4)) eoi      = wr_data;
            if (addr == off(p, 5)) m_en[p]  = wr_data;
            if (addr == off(p, 6)) m_deb[p] = wr_data;
          end
          m_stk[p] = ((m_stk[p] & ~eoi) | hit) & m_en[p] & m_edg[p];
          m_prv[p] = m_f[p];
          m_f[p]   = nf;
          void'(m_pipe[p].pop_front());
          m_pipe[p].push_back(pad_of(p));
        end
      end
      m_r2 = m_r1;
      m_r1 = 1;
    end
  end

  function automatic logic [7:0] m_stat(int p);
    return (m_stk[p] & m_en[p] & m_edg[p]) | (~m_edg[p] & m_en[p] & ~(m_f[p] ^ m_pol[p]));
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    for (int p = 0; p < 3; p++) begin
      if (a == off(p, 0)) return (m_dir[p] & m_dat[p]) | (~m_dir[p] & m_s2(p));
      if (a == off(p, 1)) return m_dir[p];
      if (a == off(p, 2)) return m_edg[p];
      if (a == off(p, 3)) return m_pol[p];
      if (a == off(p, 5)) return m_en[p];
      if (a == off(p, 6)) return m_deb[p];
      if (a == off(p, 7)) return m_stat(p);
    end
    return 8'h00;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R7 model irq_ab", {7'd0, irq_ab}, {7'd0, |{m_stat(0), m_stat(1)}});
    chk("R7 model irq_f", irq_f, m_stat(2));
    chk("R2 R3 R4 model rd_data", rd_data, m_read(addr));
    chk("R2 model oe", pad_f_oe ^ pad_b_oe ^ pad_a_oe, m_dir[0] ^ m_dir[1] ^ m_dir[2]);
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp_model();
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rchk(string tag, logic [7:0] a, logic [7:0] exp);
    addr = a;
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  // watchdog
  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_n(4);

    // R1: reset state
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 8; k++) rchk("R1 reset register", off(p, k), 8'h00);
    chk("R1 reset irq_ab", {7'd0, irq_ab}, 8'h00);
    chk("R1 reset irq_f", irq_f, 8'h00);
    chk("R1 reset oe", pad_a_oe | pad_b_oe | pad_f_oe, 8'h00);

    // R2: data and direction
    wr(8'h10, 8'hF0);
    wr(8'h00, 8'hA5);
    pad_a_in = 8'h0C;
    wait_n(4);
    chk("R2 pad_a_oe", pad_a_oe, 8'hF0);
    chk("R2 pad_a_out", pad_a_out, 8'hA5);
    rchk("R2 data readback mix", 8'h00, 8'hAC);
    wr(8'h02, 8'hFF);
    rchk("R2 unmapped read", 8'h02, 8'h00);
    rchk("R2 unmapped write ignored", 8'h14, 8'h00);

    // R3: level mode on port B pin 0
    wr(8'hB0, 8'h01);
    wr(8'hB8, 8'h01);
    wait_n(4);
    rchk("R3 level inactive", 8'hBC, 8'h00);
    pad_b_in = 8'h01;
    wait_n(4);
    rchk("R3 level high pending", 8'hBC, 8'h01);
    chk("R7 shared irq from B", {7'd0, irq_ab}, 8'h01);
    wr(8'hB4, 8'h01);
    rchk("R3 eoi ignored in level", 8'hBC, 8'h01);
    pad_b_in = 8'h00;
    wait_n(4);
    rchk("R3 level follows input", 8'hBC, 8'h00);
    wr(8'hB0, 8'h00);
    rchk("R3 low level pending", 8'hBC, 8'h01);
    wr(8'hB8, 8'h00);
    rchk("R6 disabled level pin", 8'hBC, 8'h00);
    chk("R6 disabled irq_ab", {7'd0, irq_ab}, 8'h00);

    // R4: edge mode on port A pin 1
    wr(8'h94, 8'h02);
    wr(8'h90, 8'h02);
    wr(8'h9C, 8'h02);
    pad_a_in = 8'h0E;
    wait_n(5);
    rchk("R4 rising latched", 8'hA0, 8'h02);
    pad_a_in = 8'h0C;
    wait_n(5);
    rchk("R4 sticky after return", 8'hA0, 8'h02);
    wr(8'h98, 8'h00);
    rchk("R4 eoi zero no effect", 8'hA0, 8'h02);
    wr(8'h98, 8'hFD);
    rchk("R4 eoi other bits no effect", 8'hA0, 8'h02);
    wr(8'h98, 8'h02);
    rchk("R4 eoi clears", 8'hA0, 8'h00);
    chk("R7 irq_ab cleared", {7'd0, irq_ab}, 8'h00);
    wr(8'h94, 8'h00);
    pad_a_in = 8'h0E;
    wait_n(5);
    rchk("R4 rising ignored in falling mode", 8'hA0, 8'h00);
    pad_a_in = 8'h0C;
    wait_n(5);
    rchk("R4 falling latched", 8'hA0, 8'h02);
    wr(8'h98, 8'h02);

    // R9: exact latency, then R5
    wr(8'h94, 8'h02);
    pad_a_in = 8'h0E;
    wait_n(3);
    rchk("R9 not yet at third edge", 8'hA0, 8'h00);
    cyc();
    rchk("R9 pending at fourth edge", 8'hA0, 8'h02);
    pad_a_in = 8'h0C;
    wait_n(5);
    pad_a_in = 8'h0E;
    wait_n(3);
    wr(8'h98, 8'h02);
    rchk("R5 edge beats same-cycle eoi", 8'hA0, 8'h02);
    wr(8'h98, 8'h02);
    rchk("R5 later eoi clears", 8'hA0, 8'h00);

    // R6 / R7: port F pin 3
    wr(8'h4C, 8'h08);
    wr(8'h50, 8'h08);
    pad_f_in = 8'h08;
    wait_n(5);
    chk("R6 disabled edge no irq", irq_f, 8'h00);
    rchk("R6 disabled edge no status", 8'h5C, 8'h00);
    wr(8'h58, 8'h08);
    wait_n(5);
    chk("R6 no spurious edge on enable", irq_f, 8'h00);
    pad_f_in = 8'h00;
    wait_n(5);
    pad_f_in = 8'h08;
    wait_n(5);
    chk("R7 per-pin irq_f", irq_f, 8'h08);
    chk("R7 port F not on irq_ab", {7'd0, irq_ab}, 8'h00);
    wr(8'h58, 8'h00);
    wr(8'h58, 8'h08);
    chk("R6 held edge discarded", irq_f, 8'h00);

    // R8: debounce on port F pin 0
    wr(8'h64, 8'h01);
    rchk("R10 debounce readback", 8'h64, 8'h01);
    rchk("R10 mode readback", 8'h4C, 8'h08);
    wr(8'h4C, 8'h09);
    wr(8'h50, 8'h09);
    wr(8'h58, 8'h09);
    pad_f_in = 8'h09;
    wait_n(3);
    pad_f_in = 8'h08;
    wait_n(40);
    chk("R8 short pulse dropped", irq_f & 8'h01, 8'h00);
    pad_f_in = 8'h09;
    wait_n(8);
    chk("R8 not accepted early", irq_f & 8'h01, 8'h00);
    wait_n(30);
    chk("R8 accepted after 4 ticks", irq_f & 8'h01, 8'h01);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 5) == 0) pad_a_in = pad_a_in ^ 8'($urandom_range(0, 255));
      if ($urandom_range(0, 5) == 0) pad_b_in = pad_b_in ^ 8'($urandom_range(0, 255));
      if ($urandom_range(0, 5) == 0) pad_f_in = pad_f_in ^ 8'($urandom_range(0, 255));
      addr  = off($urandom_range(0, 2), $urandom_range(0, 7));
      wr_en = ($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom_range(0, 255));
      cyc();
    end
    wr_en = 1'b0;
    wait_n(2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule